// File: doc/BRIEF.md
# Reset-Clearing Peripheral Bus Front End

This block sits between a processor-style bus and the register bank of a memory-mapped peripheral. The bus side has a 5-bit address, an 8-bit write data bus, an active-low chip select, a read/write line (high for read), a clock-phase input and an active-high synchronous reset. From these inputs the block makes three things. The first is a pair of internal address rails for every address bit, one true and one complemented. The second is an active-low internal write strobe. The third is one write-enable line for each writable register, taken from a NOR-style decoder over the rails.

Reset has no clear network of its own. While reset is high, both rails of every address bit go to 0, the internal data bus goes to 0x00 and the write strobe is forced active. Every decoder then sees only zero rails, so every writable register gets its enable at the same moment and loads 0x00. To clear all registers, reset must be held for at least one full bus cycle.

A write qualifies when chip select is low, R/W is low and the phase input is high. The write strobe waits one system clock after that condition first appears, so that address and data settle before any register is enabled. The strobe still falls inside the same bus phase, with no extra pipeline stage. A small set of readable registers is muxed onto the read data output.

Top module: `pbus_front`

## Requirements
- R1: While rst is 1, adr_t and adr_c are both all zeros, whatever the address.
- R2: While rst is 0, adr_t equals addr and adr_c equals the bitwise inverse of addr.
- R3: While rst is 1, we_n is 0, whatever cs_n, rw and phi2 are.
- R4: While rst is 1, ibus is 0x00. While rst is 0, ibus equals wdata.
- R5: While rst is 1, all 25 bits of wr_stb are 1. Every writable register (addresses 0x00 to 0x18) is enabled at the same time.
- R6: The write condition is cs_n=0, rw=0 and phi2=1. Outside reset, we_n goes low only in a clock cycle where the condition holds now and also held at the previous rising clk edge. In the first cycle of the condition, we_n stays 1. we_n returns to 1 in the same cycle the condition ends.
- R7: Outside reset, while we_n is 0 and addr is 0x00 to 0x18, wr_stb has exactly one bit set, at index addr. This happens in the same bus phase as the write. When we_n is 1, wr_stb is all zeros.
- R8: A write to any address from 0x19 to 0x1F sets no bit of wr_stb.
- R9: rdata carries byte k of rd_vals (bits 8k+7 to 8k) when rst=0, cs_n=0, rw=1, phi2=1 and addr=0x19+k, for k from 0 to 3. At every other time and address, rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| phi2 | input | 1 | Bus clock phase; a transfer is valid while it is high |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | External register address |
| wdata | input | 8 | External write data |
| rd_vals | input | 32 | Contents of the four readable registers, lowest byte at 0x19 |
| adr_t | output | 5 | True internal address rails |
| adr_c | output | 5 | Complemented internal address rails |
| we_n | output | 1 | Internal write strobe, active low |
| ibus | output | 8 | Internal data bus |
| wr_stb | output | 25 | Per-register write enables for addresses 0x00 to 0x18 |
| rdata | output | 8 | Read data |

## Verification
The block holds only one flop: the qualifying flag for the write condition. If that flag were wrong, the effect would show on we_n and wr_stb in the very next cycle of a write. It would appear either as a strobe in the first cycle of the condition or as a strobe missing in the second. Decoder or rail faults are purely combinational. They show up at once as a wrong wr_stb bit, a wrong rail value or a wrong rdata byte in the cycle the address is presented. A broken reset path shows up as a register enable missing from the all-ones reset pattern.

// File: rtl/pbus_front.sv
module pbus_front #(
  parameter int AW  = 5,
  parameter int DW  = 8,
  parameter int NWR = 25,
  parameter int NRD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              cs_n,
  input  logic              rw,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*DW-1:0] rd_vals,
  output logic [AW-1:0]     adr_t,
  output logic [AW-1:0]     adr_c,
  output logic              we_n,
  output logic [DW-1:0]     ibus,
  output logic [NWR-1:0]    wr_stb,
  output logic [DW-1:0]     rdata
);
  localparam int RD_BASE = NWR;

  logic wr_cond;
  logic wr_cond_q;
  logic rd_cond;

  assign wr_cond = ~cs_n & ~rw & phi2;
  assign rd_cond = ~rst & ~cs_n & rw & phi2;

  always_ff @(posedge clk) begin
    if (rst) wr_cond_q <= 1'b0;
    else     wr_cond_q <= wr_cond;
  end

  assign adr_t = rst ? '0 : addr;
  assign adr_c = rst ? '0 : ~addr;
  assign we_n  = ~(rst | (wr_cond & wr_cond_q));
  assign ibus  = rst ? '0 : wdata;

  generate
    for (genvar r = 0; r < NWR; r++) begin : g_wdec
      localparam logic [AW-1:0] CODE = AW'(r);
      logic [AW-1:0] rail;
      for (genvar b = 0; b < AW; b++) begin : g_bit
        assign rail[b] = CODE[b] ? adr_c[b] : adr_t[b];
      end
      assign wr_stb[r] = ~we_n & ~(|rail);
    end
  endgenerate

  logic [NRD-1:0] rd_hit;

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rdec
      localparam logic [AW-1:0] CODE = AW'(RD_BASE + k);
      logic [AW-1:0] rail;
      for (genvar b = 0; b < AW; b++) begin : g_bit
        assign rail[b] = CODE[b] ? adr_c[b] : adr_t[b];
      end
      assign rd_hit[k] = rd_cond & ~(|rail);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NRD; k++) begin
      if (rd_hit[k]) rdata = rdata | rd_vals[k*DW +: DW];
    end
  end
endmodule

// File: rtl/pbus_front_chk.sv
module pbus_front_chk #(
  parameter int AW  = 5,
  parameter int DW  = 8,
  parameter int NWR = 25,
  parameter int NRD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2,
  input logic              cs_n,
  input logic              rw,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [NRD*DW-1:0] rd_vals,
  input logic [AW-1:0]     adr_t,
  input logic [AW-1:0]     adr_c,
  input logic              we_n,
  input logic [DW-1:0]     ibus,
  input logic [NWR-1:0]    wr_stb,
  input logic [DW-1:0]     rdata
);
  logic wcond;
  assign wcond = ~cs_n & ~rw & phi2;

  always @(posedge clk) begin
    if (rst) begin
      AST_RST_RAILS: assert (adr_t == '0 && adr_c == '0); // R1
      AST_RST_WE: assert (we_n == 1'b0); // R3
      AST_RST_BUS: assert (ibus == '0); // R4
      AST_RST_ALLSTB: assert (&wr_stb); // R5
    end
  end

  AST_RAIL_PAIR: assert property (@(posedge clk) disable iff (rst)
    (adr_t == addr) && (adr_c == ~addr)); // R2
  AST_BUS_PASS: assert property (@(posedge clk) disable iff (rst)
    ibus == wdata); // R4
  AST_WE_LATE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (wcond && $past(wcond))); // R6
  AST_STB_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb) && (we_n -> wr_stb == '0)); // R7
  AST_STB_HIGH: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= NWR) |-> wr_stb == '0); // R8
  AST_RD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rw && phi2 && int'(addr) == NWR) |-> rdata == rd_vals[DW-1:0]); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && rw && phi2) |-> rdata == '0); // R9
endmodule

bind pbus_front pbus_front_chk u_chk (.*);

// File: tb/test_pbus_front.sv
module test_pbus_front;
  logic        clk = 1'b0;
  logic        rst;
  logic        phi2;
  logic        cs_n;
  logic        rw;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic [31:0] rd_vals;
  logic [4:0]  adr_t, adr_c;
  logic        we_n;
  logic [7:0]  ibus;
  logic [24:0] wr_stb;
  logic [7:0]  rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit prev_q = 1'b0;

  always #4 clk = ~clk;

  pbus_front i_pbus_front (.*);

  function automatic bit wcond(bit c, bit r, bit p);
    return !c && !r && p;
  endfunction

  function automatic logic [24:0] exp_stb(bit rs, bit we_low, logic [4:0] a);
    if (rs) return '1;
    if (we_low && a < 5'd25) return 25'(1) << a;
    return '0;
  endfunction

  function automatic logic [7:0] exp_rd(bit rs, bit c, bit r, bit p, logic [4:0] a, logic [31:0] v);
    if (!rs && !c && r && p && a >= 5'd25 && a <= 5'd28) return v[(int'(a) - 25)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(bit rs, bit c, bit r, bit p, logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    rst = rs; cs_n = c; rw = r; phi2 = p; addr = a; wdata = d;
    rd_vals = {$urandom} ;
    #1;
  endtask

  task automatic check_all(bit rs, bit c, bit r, bit p, logic [4:0] a, logic [7:0] d);
    bit we_low;
    we_low = rs || (wcond(c, r, p) && prev_q);
    if (rs) check(adr_t == 0 && adr_c == 0, "R1 rails", {adr_t, adr_c}, 0);
    else check(adr_t == a && adr_c == ~a, "R2 rails", {adr_t, adr_c}, {a, ~a});
    if (rs) check(we_n == 1'b0, "R3 we_n", we_n, 0);
    else check(we_n == !we_low, "R6 we_n", we_n, !we_low);
    check(ibus == (rs ? 8'h00 : d), "R4 ibus", ibus, rs ? 0 : d);
    if (rs) check(wr_stb == '1, "R5 strobes", wr_stb, '1);
    else if (a >= 5'd25) check(wr_stb == '0, "R8 strobes", wr_stb, 0);
    else check(wr_stb == exp_stb(rs, we_low, a), "R7 strobes", wr_stb, exp_stb(rs, we_low, a));
    check(rdata == exp_rd(rs, c, r, p, a, rd_vals), "R9 rdata", rdata, exp_rd(rs, c, r, p, a, rd_vals));
  endtask

  task automatic step(bit rs, bit c, bit r, bit p, logic [4:0] a, logic [7:0] d);
    apply(rs, c, r, p, a, d);
    check_all(rs, c, r, p, a, d);
    prev_q = !rs && wcond(c, r, p);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cs_n = 1'b1; rw = 1'b1; phi2 = 1'b0; addr = '0; wdata = '0; rd_vals = '0;
    step(1, 1, 1, 0, 5'h00, 8'h00);
    step(1, 0, 0, 1, 5'h1f, 8'hff);
    step(1, 0, 1, 1, 5'h19, 8'h5a);
    step(0, 1, 1, 0, 5'h07, 8'h11);
    // R6: first cycle of a write has no strobe, second does, release is immediate
    step(0, 0, 0, 1, 5'h03, 8'ha5);
    step(0, 0, 0, 1, 5'h03, 8'ha5);
    step(0, 0, 0, 0, 5'h03, 8'ha5);
    // R7 boundary: highest writable address
    step(0, 0, 0, 1, 5'h18, 8'h3c);
    step(0, 0, 0, 1, 5'h18, 8'h3c);
    // R8: write to readable and unused addresses
    step(0, 0, 0, 1, 5'h19, 8'h77);
    step(0, 0, 0, 1, 5'h1f, 8'h77);
    step(0, 0, 0, 1, 5'h1c, 8'h77);
    // R9: every readable address, and an unused one
    for (int k = 25; k < 32; k++) step(0, 0, 1, 1, 5'(k), 8'h00);
    step(0, 0, 1, 0, 5'h1a, 8'h00);
    // R5: reset in mid write clears the qualifier
    step(0, 0, 0, 1, 5'h00, 8'h01);
    step(1, 0, 0, 1, 5'h00, 8'h01);
    step(0, 0, 0, 1, 5'h00, 8'h01);
    step(0, 0, 0, 1, 5'h00, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      bit rs = ($urandom % 20) == 0;
      bit c  = ($urandom % 4) == 0;
      bit r  = $urandom % 2;
      bit p  = ($urandom % 4) != 0;
      step(rs, c, r, p, 5'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule